// File: doc/BRIEF.md
# Frame-Counted SPI Master

This block is an SPI master that software drives through a small register bus. Before a burst, software programs a transfer mode, a frame count, a clock divider and a receive sample delay while the block is disabled. It then fills a 32-entry transmit FIFO and sets the enable register. The master shifts the programmed number of 8-bit frames on SCLK and MOSI and samples MISO into a 32-entry receive FIFO. The single active-low slave select is a plain register bit, so software can hold a device selected across several bursts.

The master has three transfer modes. Duplex mode sends and receives. Transmit-only mode sends and discards what it receives. Receive-only mode produces its own clocks with no transmit data and drives MOSI low. Software polls a busy flag to learn when a burst has finished. It then reads received frames either one byte per read or, when byte access is cleared, two bytes per read.

Register map (word address on `bus_addr`): 0 enable (bit 0), 1 control, 2 frame count minus one, 3 divider, 4 select (bit 0), 5 status, 6 receive level, 7 transmit data, 8 receive data. The control fields are: bits [1:0] mode (0 duplex, 1 transmit-only, 2 receive-only), bit 2 byte access (1 after reset), bits [4:3] sample delay. The status bits are: bit 0 busy, bit 1 transmit FIFO full, bit 2 receive FIFO empty. Read data appears on `bus_rdata` one clock after the read strobe.

Top module: `spim_core`

## Requirements
- R1: After reset, `ss_n` is 1, `sclk` is 0, status reads busy 0, tx-full 0 and rx-empty 1, and the receive level reads 0.
- R2: SCLK idles low. Each high phase lasts divider/2 clocks. MOSI changes only while SCLK is low, and each frame is sent most significant bit first.
- R3: Writes to control, frame count and divider have no effect while enable is 1. Writing 0 to enable ends any burst and clears busy.
- R4: In duplex mode (mode 0), each of the count+1 frames sends one transmit FIFO byte and pushes the sampled MISO byte into the receive FIFO.
- R5: In transmit-only mode (mode 1), no received frame enters the receive FIFO.
- R6: In receive-only mode (mode 2), exactly count+1 frames are clocked with an empty transmit FIFO, and MOSI is held at 0.
- R7: In duplex or transmit-only mode, when the transmit FIFO is empty before a frame, SCLK stays low and busy stays 1 until data is written. The burst then resumes.
- R8: With byte access 0, a receive data read returns the earlier byte in bits [7:0] and the later byte in bits [15:8], and pops both.
- R9: A transmit write while that FIFO holds 32 entries is dropped, and status bit 1 reads 1. A receive data read of an empty FIFO returns 0.
- R10: A burst makes exactly 8×(count+1) rising SCLK edges. The first rising edge comes at least one divider period after enable is set. Busy stays 1 until the last frame has finished.
- R11: `ss_n` is the inverse of select bit 0, one clock after the write, and holds across bursts.
- R12: MISO is taken the number of clocks given by the sample delay (0 to 3) after the clock that follows each rising SCLK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after bus_rd |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
Two things can land in the same clock: the pop of a transmit byte at a frame boundary and a software write to the transmit FIFO. The bench provokes this by starting a duplex burst with only one byte queued. It waits until the shifter is stalled and then writes the remaining bytes. The result is judged by the exact count of rising edges and by the MOSI bytes the bench's slave model collects. A second case makes the late MISO sample of a frame coincide with a receive FIFO push. Here the slave model flips MISO partway through each high phase, and the bench checks which value each sample delay captures.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    XM_DUPLEX = 2'd0,
    XM_TXONLY = 2'd1,
    XM_RXONLY = 2'd2
  } xfer_mode_e;

  localparam logic [3:0] A_ENABLE = 4'd0;
  localparam logic [3:0] A_CTRL   = 4'd1;
  localparam logic [3:0] A_COUNT  = 4'd2;
  localparam logic [3:0] A_DIV    = 4'd3;
  localparam logic [3:0] A_SELECT = 4'd4;
  localparam logic [3:0] A_STATUS = 4'd5;
  localparam logic [3:0] A_RXLVL  = 4'd6;
  localparam logic [3:0] A_TXDATA = 4'd7;
  localparam logic [3:0] A_RXDATA = 4'd8;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  input  logic          pop2,
  output logic [W-1:0]  head0,
  output logic [W-1:0]  head1,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok;
  logic [1:0]    pop_n;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign head0   = mem[rd_ptr];
  assign head1   = mem[rd_ptr + AW'(1)];

  always_comb begin
    pop_n = 2'd0;
    if (pop && !empty) pop_n = (pop2 && level >= LW'(2)) ? 2'd2 : 2'd1;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr <= rd_ptr + AW'(pop_n);
      level  <= level + LW'(push_ok) - LW'(pop_n);
    end
  end

  assert_level_bound_R9: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  assert_full_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (level == $past(level)));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             start,
  input  xfer_mode_e       mode,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] frames_m1,
  input  logic [1:0]       smp_dly,
  input  logic             miso,
  input  logic             tx_empty,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [7:0]       rx_byte,
  output logic             sclk,
  output logic             mosi,
  output logic             busy
);
  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_FETCH, S_LOW, S_HIGH, S_DRAIN} st_e;

  st_e              state;
  logic [DIV_W-1:0] tmr, half_m1, lead_m1;
  logic [CNT_W-1:0] left;
  logic [2:0]       bit_idx, rx_bits;
  logic [7:0]       sh;
  logic [6:0]       rx_sh;
  logic [3:0]       evt;
  logic             need_tx, take;

  assign need_tx = (mode != XM_RXONLY);
  assign half_m1 = ((div >> 1) == '0) ? '0 : (div >> 1) - DIV_W'(1);
  assign lead_m1 = (div == '0) ? '0 : div - DIV_W'(1);
  assign tx_pop  = (state == S_FETCH) && need_tx && !tx_empty;
  assign take    = evt[smp_dly];

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      state <= S_IDLE; tmr <= '0; left <= '0; bit_idx <= '0;
      sh <= '0; sclk <= 1'b0; mosi <= 1'b0; busy <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_LEAD; tmr <= lead_m1; left <= frames_m1; busy <= 1'b1;
        end
        S_LEAD: if (tmr == '0) state <= S_FETCH; else tmr <= tmr - DIV_W'(1);
        S_FETCH: if (!(need_tx && tx_empty)) begin
          sh      <= need_tx ? tx_data : 8'h00;
          mosi    <= need_tx ? tx_data[7] : 1'b0;
          bit_idx <= 3'd7;
          tmr     <= half_m1;
          state   <= S_LOW;
        end
        S_LOW: if (tmr == '0) begin
          sclk <= 1'b1; tmr <= half_m1; state <= S_HIGH;
        end else tmr <= tmr - DIV_W'(1);
        S_HIGH: if (tmr == '0) begin
          sclk <= 1'b0;
          if (bit_idx == 3'd0) begin
            if (left == '0) begin
              state <= S_DRAIN; tmr <= DIV_W'(4);
            end else begin
              left <= left - CNT_W'(1); state <= S_FETCH;
            end
          end else begin
            bit_idx <= bit_idx - 3'd1;
            sh      <= {sh[6:0], 1'b0};
            mosi    <= sh[6];
            tmr     <= half_m1;
            state   <= S_LOW;
          end
        end else tmr <= tmr - DIV_W'(1);
        S_DRAIN: if (tmr == '0) begin
          state <= S_IDLE; busy <= 1'b0;
        end else tmr <= tmr - DIV_W'(1);
        default: state <= S_IDLE;
      endcase
    end
  end

  // Receive path: a rising-edge event delayed by the sample delay picks the MISO instant.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      evt <= '0; rx_bits <= '0; rx_sh <= '0; rx_push <= 1'b0; rx_byte <= '0;
    end else begin
      evt     <= {evt[2:0], (state == S_LOW) && (tmr == '0)};
      rx_push <= 1'b0;
      if (start) rx_bits <= '0;
      else if (take) begin
        rx_sh   <= {rx_sh[5:0], miso};
        rx_bits <= rx_bits + 3'd1;
        if (rx_bits == 3'd7) begin
          rx_push <= (mode != XM_TXONLY);
          rx_byte <= {rx_sh, miso};
        end
      end
    end
  end

  assert_rise_busy_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> busy);
  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));
  assert_stall_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (run && state == S_FETCH && need_tx && tx_empty) |=> (!sclk && busy));
  assert_rxonly_mosi_R6: assert property (@(posedge clk) disable iff (rst)
    (run && busy && mode == XM_RXONLY && $past(mode) == XM_RXONLY) |-> !mosi);
endmodule

// File: rtl/spim_core.sv
module spim_core
  import spim_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 32,
  localparam int LW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        ss_n
);
  logic             enable_q, start_q, byte_acc;
  xfer_mode_e       mode_q;
  logic [1:0]       dly_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cfg_open, wr_en;

  logic             tx_pop, tx_full, tx_empty;
  logic [7:0]       tx_head, tx_unused;
  logic [LW-1:0]    tx_level;
  logic             rx_push, rx_pop, rx_full, rx_empty;
  logic [7:0]       rx_byte, rx_h0, rx_h1;
  logic [LW-1:0]    rx_level;
  logic             busy;

  assign cfg_open = !enable_q;
  assign wr_en    = bus_wr && bus_addr == A_ENABLE;
  assign rx_pop   = bus_rd && bus_addr == A_RXDATA;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= 1'b0; start_q <= 1'b0; byte_acc <= 1'b1; mode_q <= XM_DUPLEX;
      dly_q <= '0; div_q <= DIV_W'(2); cnt_q <= '0; ss_n <= 1'b1;
    end else begin
      start_q <= wr_en && bus_wdata[0] && !enable_q;
      if (wr_en) enable_q <= bus_wdata[0];
      if (bus_wr && bus_addr == A_SELECT) ss_n <= !bus_wdata[0];
      if (bus_wr && cfg_open) begin
        if (bus_addr == A_CTRL) begin
          mode_q   <= xfer_mode_e'(bus_wdata[1:0]);
          byte_acc <= bus_wdata[2];
          dly_q    <= bus_wdata[4:3];
        end
        if (bus_addr == A_COUNT) cnt_q <= bus_wdata[CNT_W-1:0];
        if (bus_addr == A_DIV)   div_q <= bus_wdata[DIV_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_ENABLE: bus_rdata <= 32'(enable_q);
        A_CTRL:   bus_rdata <= 32'({dly_q, byte_acc, mode_q});
        A_COUNT:  bus_rdata <= 32'(cnt_q);
        A_DIV:    bus_rdata <= 32'(div_q);
        A_SELECT: bus_rdata <= 32'(!ss_n);
        A_STATUS: bus_rdata <= 32'({rx_empty, tx_full, busy});
        A_RXLVL:  bus_rdata <= 32'(rx_level);
        A_RXDATA: bus_rdata <= rx_empty ? 32'd0 :
                   (!byte_acc && rx_level >= LW'(2)) ? 32'({rx_h1, rx_h0}) : 32'(rx_h0);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  spim_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(bus_wr && bus_addr == A_TXDATA), .din(bus_wdata[7:0]),
    .pop(tx_pop), .pop2(1'b0), .head0(tx_head), .head1(tx_unused),
    .level(tx_level), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .pop2(!byte_acc), .head0(rx_h0), .head1(rx_h1),
    .level(rx_level), .full(rx_full), .empty(rx_empty));

  spim_shifter #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .run(enable_q), .start(start_q), .mode(mode_q),
    .div(div_q), .frames_m1(cnt_q), .smp_dly(dly_q), .miso(miso),
    .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_byte(rx_byte), .sclk(sclk), .mosi(mosi), .busy(busy));

  assert_idle_clock_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);
  assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (enable_q && $past(enable_q)) |-> ($stable(div_q) && $stable(cnt_q) && $stable(mode_q)));
  assert_select_direct_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_SELECT) |=> (ss_n == !$past(bus_wdata[0])));
  assert_txonly_norx_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == XM_TXONLY && enable_q && $past(enable_q) && !rx_pop) |=> (rx_level <= $past(rx_level)));
endmodule

// File: tb/test_spim_core.sv
`timescale 1ns/1ps
module test_spim_core;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic sclk, mosi, ss_n;
  logic miso = 1'b0;

  int checks = 0, fails = 0;
  int s_frame, s_bit, s_hi, s_rises, half_exp, seed, lat, lat_first;
  logic prev_sclk = 1'b0;
  logic alt_en = 1'b0;
  logic [7:0] s_acc;
  logic [7:0] s_got [64];

  always #10 clk = ~clk;

  spim_core i_spim_core (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

  function automatic logic [7:0] orig(int f);
    return 8'((f * 71 + seed) & 255);
  endfunction
  function automatic logic [7:0] txb(int i, int base);
    return 8'((i * 53 + base) & 255);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Slave model: samples on SCLK rising, presents the next bit after falling.
  always @(negedge clk) begin
    lat++;
    if (sclk && !prev_sclk) begin
      s_acc = {s_acc[6:0], mosi};
      s_hi = 1;
      s_rises++;
      if (lat_first < 0) lat_first = lat;
    end else if (sclk) s_hi++;
    if (sclk && alt_en && s_hi == 3) miso = ~orig(s_frame)[7 - s_bit];
    if (!sclk && prev_sclk) begin
      check(s_hi == half_exp, "R2 high phase", s_hi, half_exp);
      s_bit++;
      if (s_bit == 8) begin
        s_got[s_frame % 64] = s_acc;
        s_frame++;
        s_bit = 0;
      end
      miso = orig(s_frame)[7 - s_bit];
    end
    prev_sclk = sclk;
  end

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic bus_read(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic configure(int mode, int bacc, int dly, int div, int n);
    bus_write(4'd0, 0);
    bus_write(4'd1, 32'((dly << 3) | (bacc << 2) | mode));
    bus_write(4'd3, 32'(div));
    bus_write(4'd2, 32'(n - 1));
    half_exp = div / 2;
    s_frame = 0; s_bit = 0; s_rises = 0; s_hi = 0;
    miso = orig(0)[7];
  endtask
  task automatic push_tx(int from, int to, int base);
    for (int i = from; i < to; i++) bus_write(4'd7, 32'(txb(i, base)));
  endtask
  task automatic start_burst();
    bus_write(4'd0, 1);
    lat = 0; lat_first = -1;
    repeat (3) @(negedge clk);
  endtask
  task automatic wait_idle();
    logic [31:0] v;
    do bus_read(4'd5, v); while (v[0]);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int divs[2] = '{8, 12};
    seed = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(ss_n == 1'b1, "R1 ss_n", ss_n, 1);
    check(sclk == 1'b0, "R1 sclk", sclk, 0);
    bus_read(4'd5, v); check(v[2:0] == 3'b100, "R1 status", v, 4);
    bus_read(4'd6, v); check(v == 0, "R1 rx level", v, 0);

    // R11 select drives ss_n directly
    bus_write(4'd4, 1);
    check(ss_n == 1'b0, "R11 select on", ss_n, 0);

    // R4 / R2 / R10 duplex sweep
    foreach (divs[k]) begin
      for (int n = 1; n <= 5; n += 2) begin
        seed = divs[k] + n;
        configure(0, 1, 0, divs[k], n);
        push_tx(0, n, divs[k]);
        start_burst();
        wait_idle();
        check(s_rises == 8 * n, "R10 rising edge count", s_rises, 8 * n);
        check(lat_first >= divs[k], "R10 lead delay", lat_first, divs[k]);
        for (int i = 0; i < n; i++)
          check(s_got[i] == txb(i, divs[k]), "R2 MSB-first mosi", s_got[i], txb(i, divs[k]));
        bus_read(4'd6, v); check(v == n, "R4 rx level", v, n);
        for (int i = 0; i < n; i++) begin
          bus_read(4'd8, v); check(v == 32'(orig(i)), "R4 rx data", v, orig(i));
        end
      end
    end
    check(ss_n == 1'b0, "R11 select held", ss_n, 0);

    // R5 transmit-only
    seed = 90;
    configure(1, 1, 0, 8, 4);
    push_tx(0, 4, 7);
    start_burst(); wait_idle();
    bus_read(4'd6, v); check(v == 0, "R5 no rx push", v, 0);
    check(s_got[3] == txb(3, 7), "R5 tx byte", s_got[3], txb(3, 7));

    // R6 / R8 receive-only, packed
    seed = 13;
    configure(2, 0, 0, 8, 6);
    start_burst(); wait_idle();
    check(s_rises == 48, "R6 frames clocked", s_rises, 48);
    for (int i = 0; i < 6; i++) check(s_got[i] == 8'h00, "R6 mosi low", s_got[i], 0);
    for (int i = 0; i < 3; i++) begin
      bus_read(4'd8, v);
      check(v == 32'({orig(2 * i + 1), orig(2 * i)}), "R8 packed read", v, {orig(2 * i + 1), orig(2 * i)});
    end
    // R6 receive-only, byte access
    seed = 200;
    configure(2, 1, 0, 8, 3);
    start_burst(); wait_idle();
    check(s_rises == 24, "R6 frames clocked byte", s_rises, 24);
    for (int i = 0; i < 3; i++) begin
      bus_read(4'd8, v); check(v == 32'(orig(i)), "R6 rx byte", v, orig(i));
    end

    // R12 sample delay sweep
    for (int d = 0; d < 4; d++) begin
      seed = 40 + d;
      configure(0, 1, d, 8, 2);
      alt_en = 1'b1;
      push_tx(0, 2, 3);
      start_burst(); wait_idle();
      alt_en = 1'b0;
      for (int i = 0; i < 2; i++) begin
        logic [7:0] e;
        e = (d >= 2) ? ~orig(i) : orig(i);
        bus_read(4'd8, v); check(v == 32'(e), "R12 sample instant", v, e);
      end
    end

    // R7 stall on empty tx, R3 config frozen while enabled
    seed = 5;
    configure(0, 1, 0, 8, 3);
    push_tx(0, 1, 9);
    start_burst();
    repeat (300) @(negedge clk);
    check(s_rises == 8, "R7 stalled edges", s_rises, 8);
    bus_read(4'd5, v); check(v[0] == 1'b1, "R7 busy while stalled", v[0], 1);
    bus_write(4'd3, 20);
    bus_read(4'd3, v); check(v == 8, "R3 divider frozen", v, 8);
    push_tx(1, 3, 9);
    wait_idle();
    check(s_rises == 24, "R7 resumed edges", s_rises, 24);
    check(s_got[2] == txb(2, 9), "R7 resumed data", s_got[2], txb(2, 9));
    bus_read(4'd6, v); check(v == 3, "R7 rx level", v, 3);
    for (int i = 0; i < 3; i++) bus_read(4'd8, v);

    // R9 full tx drop, empty rx read
    seed = 77;
    configure(0, 1, 0, 8, 32);
    push_tx(0, 33, 11);
    bus_read(4'd5, v); check(v[1] == 1'b1, "R9 tx full flag", v[1], 1);
    start_burst(); wait_idle();
    check(s_got[31] == txb(31, 11), "R9 last kept byte", s_got[31], txb(31, 11));
    bus_read(4'd6, v); check(v == 32, "R9 rx level full", v, 32);
    for (int i = 0; i < 32; i++) begin
      bus_read(4'd8, v);
      if (i == 0 || i == 31) check(v == 32'(orig(i)), "R4 rx data deep", v, orig(i));
    end
    bus_read(4'd8, v); check(v == 0, "R9 empty rx read", v, 0);
    configure(0, 1, 0, 8, 1);
    start_burst();
    repeat (100) @(negedge clk);
    check(s_rises == 0, "R9 dropped byte absent", s_rises, 0);
    bus_write(4'd0, 0);
    bus_read(4'd5, v); check(v[0] == 1'b0, "R3 disable clears busy", v[0], 0);

    bus_write(4'd4, 0);
    check(ss_n == 1'b1, "R11 select off", ss_n, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule